// File: doc/BRIEF.md
# Nibble-Wide Host Command Port

This block is the slave end of a narrow host link into a controller's register file. The host frames each transaction with an active-low select and clocks nibbles over a 4-bit data path with its own strobe. Command and data bytes travel as high-nibble-then-low-nibble pairs. The block assembles the nibbles and classifies the transaction by its first nibble. When the select is released, it commits a completed write into an internal register bank. For read commands it turns the data path around and returns a status vector one nibble at a time.

The host strobe and select are asynchronous to the block clock. Both pass through synchronizers, and edges are detected in the block clock domain. The bidirectional pad is modelled as separate input, output and output-enable ports. A registered readback port on the register bank lets the surrounding controller use the stored values.

Top module: `nib_host_if`

## Requirements
- R1: After a synchronous active-high reset, `bus_oe_o` and `err_o` are 0 and the interface is idle.
- R2: A normal write carries command-high, command-low, data-high and data-low nibbles, each sampled on a rising strobe edge. When the select rises, register[command-low] becomes {8'h00, data byte}. The value can be read on `rd_data_o` one clock after `rd_addr_i` is applied.
- R3: Commands with a high nibble of 4'hE or 4'hF are extended writes of six nibbles. After the data byte comes an extra byte, and register[command-low] becomes {data byte, extra byte}.
- R4: The command high nibble picks the transaction type: 4'hC is a read, 4'hE and 4'hF are extended writes, and every other value is a normal write. The nibble count expected follows from that type.
- R5: In a read, the host sends the single nibble 4'hC. Each later falling strobe edge enables the output and presents the next nibble of the status vector, most significant nibble first. The vector is captured at the command nibble.
- R6: After the last status nibble, the next rising strobe edge releases the output.
- R7: Raising the select during a read releases the output and reports no error.
- R8: If the select rises during a write before all nibbles have arrived, no register changes and `err_o` pulses for exactly one clock.
- R9: A write with more nibbles than its type expects writes nothing and pulses `err_o`.
- R10: If the select falls again fewer than GAP_CYC clocks after it last rose, that whole transaction is ignored: no write and no error.
- R11: A select pulse with no strobe edges writes nothing and reports no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n_i | input | 1 | Host select, active low |
| stb_i | input | 1 | Host strobe clock |
| bus_i | input | 4 | Nibble data path from the host |
| bus_o | output | 4 | Read nibble towards the host |
| bus_oe_o | output | 1 | Output enable for the nibble data path |
| stat_i | input | STAT_W | Status vector returned by reads |
| rd_addr_i | input | ADDR_W | Register bank readback address |
| rd_data_o | output | 16 | Registered readback data |
| err_o | output | 1 | One-clock pulse on a malformed write |

## Verification
The hardest case to reach is a select that falls back too soon after a completed transaction. It needs an exact short high interval on the select, followed by a fully formed write whose effect must then be shown to be absent. The stimulus closes one write normally, holds the select high for two clocks only, and then sends a complete write to another address. Reading both registers back shows that the first write landed and the second was dropped without an error pulse. Read turnaround is exercised by stepping the strobe one edge at a time and sampling the output between edges.

// File: rtl/nib_pkg.sv
package nib_pkg;
  typedef enum logic [1:0] {T_NORM, T_EXT, T_READ} xfer_e;
  typedef enum logic [1:0] {S_IDLE, S_ACT, S_BLK} fstate_e;

  function automatic xfer_e classify(logic [3:0] hi, logic [3:0] rd_grp,
                                     logic [3:0] ext_a, logic [3:0] ext_b);
    if (hi == rd_grp) return T_READ;
    if (hi == ext_a || hi == ext_b) return T_EXT;
    return T_NORM;
  endfunction
endpackage

// File: rtl/nib_sync.sv
module nib_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] q_d
);
  logic [W-1:0] stg [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= RST_VAL;
        else if (g == 0) stg[g] <= d;
        else stg[g] <= stg[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) q_d <= RST_VAL;
    else q_d <= stg[STAGES-1];
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/nib_regbank.sv
module nib_regbank #(
  parameter int NREG = 16,
  parameter int DW = 16,
  localparam int AW = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [DW-1:0] wd,
  input  logic [AW-1:0] ra,
  output logic [DW-1:0] rd_q
);
  logic [DW-1:0] mem [NREG];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    rd_q <= mem[ra];
  end

  // R2: a written value is visible on the readback port two clocks later
  p_readback_r2: assert property (@(posedge clk) disable iff (rst)
    (we && ra == wa) ##1 (ra == $past(wa)) |=> rd_q == $past(wd, 2));
endmodule

// File: rtl/nib_frame.sv
module nib_frame import nib_pkg::*; #(
  parameter int STAT_W = 16,
  parameter int AW = 4,
  parameter int GAP_CYC = 8,
  parameter logic [3:0] READ_GRP = 4'hC,
  parameter logic [3:0] EXT_GRP_A = 4'hE,
  parameter logic [3:0] EXT_GRP_B = 4'hF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n_s,
  input  logic              cs_n_d,
  input  logic              stb_s,
  input  logic              stb_d,
  input  logic [3:0]        nib_s,
  input  logic [STAT_W-1:0] stat_i,
  output logic              wr_en,
  output logic [AW-1:0]     wr_addr,
  output logic [15:0]       wr_data,
  output logic [3:0]        bus_q,
  output logic              oe_q,
  output logic              err_q
);
  localparam int NRD = STAT_W / 4;
  localparam int RIW = $clog2(NRD + 1);
  localparam int GW  = $clog2(GAP_CYC + 1);

  fstate_e state;
  xfer_e   typ;
  logic [2:0]        cnt;
  logic [23:0]       shreg;
  logic [STAT_W-1:0] snap;
  logic [RIW-1:0]    ridx;
  logic [GW-1:0]     gap;

  wire cs_fall  = cs_n_d & ~cs_n_s;
  wire cs_rise  = ~cs_n_d & cs_n_s;
  wire stb_rise = stb_s & ~stb_d;
  wire stb_fall = ~stb_s & stb_d;
  wire gap_ok   = (gap >= GW'(GAP_CYC));
  wire rd_phase = (typ == T_READ) && (cnt != 3'd0);
  wire len_ok   = (typ == T_NORM && cnt == 3'd4) || (typ == T_EXT && cnt == 3'd6);
  logic [STAT_W-1:0] snap_sh;
  assign snap_sh = snap << (4 * ridx);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE; typ <= T_NORM; cnt <= '0; shreg <= '0; snap <= '0;
      ridx <= '0; gap <= GW'(GAP_CYC); oe_q <= 1'b0; bus_q <= '0;
      wr_en <= 1'b0; err_q <= 1'b0; wr_addr <= '0; wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      err_q <= 1'b0;
      case (state)
        S_IDLE: begin
          if (cs_n_s && !gap_ok) gap <= gap + 1'b1;
          if (cs_fall) begin
            if (gap_ok) begin
              state <= S_ACT; cnt <= '0; ridx <= '0; shreg <= '0;
            end else state <= S_BLK;
          end
        end
        S_BLK: if (cs_rise) begin state <= S_IDLE; gap <= '0; end
        S_ACT: begin
          if (cs_rise) begin
            state <= S_IDLE; gap <= '0; oe_q <= 1'b0;
            if (typ == T_EXT) begin
              wr_addr <= AW'(shreg[19:16]); wr_data <= shreg[15:0];
            end else begin
              wr_addr <= AW'(shreg[11:8]); wr_data <= {8'h00, shreg[7:0]};
            end
            if (len_ok) wr_en <= 1'b1;
            else if (typ != T_READ && cnt != 3'd0) err_q <= 1'b1;
          end else begin
            if (stb_rise) begin
              shreg <= {shreg[19:0], nib_s};
              if (cnt != 3'd7) cnt <= cnt + 1'b1;
              if (cnt == 3'd0) begin
                typ  <= classify(nib_s, READ_GRP, EXT_GRP_A, EXT_GRP_B);
                snap <= stat_i;
              end
              if (rd_phase && ridx == RIW'(NRD)) oe_q <= 1'b0;
            end
            if (stb_fall && rd_phase && ridx < RIW'(NRD)) begin
              oe_q  <= 1'b1;
              bus_q <= snap_sh[STAT_W-1 -: 4];
              ridx  <= ridx + 1'b1;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R5: only a read transaction may drive the data path
  p_oe_read_only_r5: assert property (@(posedge clk) disable iff (rst)
    oe_q |-> typ == T_READ);
  // R5: the driver turns on only after a falling strobe edge
  p_oe_on_fall_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(oe_q) |-> $past(stb_fall));
  // R7: the data path is released whenever no transaction is open
  p_oe_closed_r7: assert property (@(posedge clk) disable iff (rst)
    state != S_ACT |-> !oe_q);
  // R8: the error indication lasts one clock
  p_err_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    err_q |=> !err_q);
  // R2: a register write only follows the close of an open transaction
  p_wr_on_close_r2: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> state == S_IDLE && $past(state) == S_ACT);
  // R10: an ignored transaction neither writes nor flags
  p_blocked_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    state == S_BLK |=> !wr_en && !err_q);
endmodule

// File: rtl/nib_host_if.sv
module nib_host_if #(
  parameter int STAT_W = 16,
  parameter int NREG = 16,
  parameter int GAP_CYC = 8,
  parameter int SYNC_STAGES = 2,
  localparam int ADDR_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n_i,
  input  logic              stb_i,
  input  logic [3:0]        bus_i,
  output logic [3:0]        bus_o,
  output logic              bus_oe_o,
  input  logic [STAT_W-1:0] stat_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [15:0]       rd_data_o,
  output logic              err_o
);
  logic [5:0] in_s, in_d;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [15:0]       wr_data;

  nib_sync #(.W(6), .STAGES(SYNC_STAGES), .RST_VAL(6'b110000)) u_sync (
    .clk(clk), .rst(rst), .d({cs_n_i, stb_i, bus_i}), .q(in_s), .q_d(in_d));

  nib_frame #(.STAT_W(STAT_W), .AW(ADDR_W), .GAP_CYC(GAP_CYC)) u_frame (
    .clk(clk), .rst(rst), .cs_n_s(in_s[5]), .cs_n_d(in_d[5]),
    .stb_s(in_s[4]), .stb_d(in_d[4]), .nib_s(in_s[3:0]), .stat_i(stat_i),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .bus_q(bus_o), .oe_q(bus_oe_o), .err_q(err_o));

  nib_regbank #(.NREG(NREG), .DW(16)) u_bank (
    .clk(clk), .rst(rst), .we(wr_en), .wa(wr_addr), .wd(wr_data),
    .ra(rd_addr_i), .rd_q(rd_data_o));
endmodule

// File: tb/nib_host_if_bench.sv
module nib_host_if_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HP = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n_i = 1'b1, stb_i = 1'b0;
  logic [3:0] bus_i = '0;
  logic [3:0] bus_o;
  logic bus_oe_o, err_o;
  logic [15:0] stat_i = 16'hA5C3;
  logic [3:0] rd_addr_i = '0;
  logic [15:0] rd_data_o;

  int n_chk = 0, n_bad = 0, n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) if (!rst && err_o === 1'b1) n_err++;

  nib_host_if u_nib_host_if (.*);

  task automatic cyc(int n); repeat (n) @(posedge clk); endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic nib(logic [3:0] v);
    @(negedge clk) bus_i = v; cyc(HP);
    @(negedge clk) stb_i = 1'b1; cyc(HP);
    @(negedge clk) stb_i = 1'b0; cyc(HP);
  endtask

  task automatic open_tx(); @(negedge clk) cs_n_i = 1'b0; cyc(HP); endtask
  task automatic close_tx(); @(negedge clk) cs_n_i = 1'b1; cyc(20); endtask

  task automatic write_bytes(logic [7:0] c, logic [7:0] d);
    open_tx(); nib(c[7:4]); nib(c[3:0]); nib(d[7:4]); nib(d[3:0]); close_tx();
  endtask

  task automatic rdreg(logic [3:0] a, output logic [15:0] v);
    @(negedge clk) rd_addr_i = a; cyc(3);
    @(negedge clk) v = rd_data_o;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 oe", bus_oe_o, 0);
    check("R1 err", err_o, 0);
  endtask

  task automatic t_normal();
    logic [15:0] v; int e0 = n_err;
    write_bytes(8'h13, 8'h7E); rdreg(4'h3, v);
    check("R2 normal write", v, 16'h007E);
    write_bytes(8'h52, 8'hC4); rdreg(4'h2, v);
    check("R4 other group is normal", v, 16'h00C4);
    check("R2 no error", n_err - e0, 0);
  endtask

  task automatic t_ext();
    logic [15:0] v;
    open_tx(); nib(4'hE); nib(4'h5); nib(4'h1); nib(4'h2); nib(4'h3); nib(4'h4); close_tx();
    rdreg(4'h5, v); check("R3 ext group E", v, 16'h1234);
    open_tx(); nib(4'hF); nib(4'h6); nib(4'hA); nib(4'hB); nib(4'hC); nib(4'hD); close_tx();
    rdreg(4'h6, v); check("R3 ext group F", v, 16'hABCD);
  endtask

  task automatic t_read();
    logic [15:0] exp = 16'hA5C3; logic [15:0] v; int e0 = n_err;
    open_tx(); nib(4'hC);
    check("R5 nibble 0 oe", bus_oe_o, 1);
    check("R5 nibble 0", bus_o, exp[15:12]);
    for (int i = 1; i < 4; i++) begin
      @(negedge clk) stb_i = 1'b1; cyc(HP);
      check("R5 oe held", bus_oe_o, 1);
      @(negedge clk) stb_i = 1'b0; cyc(HP);
      check("R5 next nibble", bus_o, 32'(exp[15 - 4*i -: 4]));
    end
    @(negedge clk) stb_i = 1'b1; cyc(HP);
    check("R6 released after last", bus_oe_o, 0);
    @(negedge clk) stb_i = 1'b0; cyc(HP);
    close_tx();
    check("R5 read no error", n_err - e0, 0);
    rdreg(4'h3, v); check("R5 read writes nothing", v, 16'h007E);
  endtask

  task automatic t_read_abort();
    int e0 = n_err;
    open_tx(); nib(4'hC);
    @(negedge clk) stb_i = 1'b1; cyc(HP);
    @(negedge clk) stb_i = 1'b0; cyc(HP);
    check("R7 second nibble", bus_o, 4'h5);
    @(negedge clk) cs_n_i = 1'b1; cyc(HP);
    check("R7 released on select", bus_oe_o, 0);
    cyc(20);
    check("R7 no error", n_err - e0, 0);
  endtask

  task automatic t_abort_write();
    logic [15:0] v; int e0 = n_err;
    open_tx(); nib(4'h1); nib(4'h3); nib(4'h9); close_tx();
    rdreg(4'h3, v); check("R8 short write ignored", v, 16'h007E);
    check("R8 one error pulse", n_err - e0, 1);
  endtask

  task automatic t_overrun();
    logic [15:0] v; int e0 = n_err;
    open_tx(); nib(4'h1); nib(4'h3); nib(4'h4); nib(4'h4); nib(4'h4); close_tx();
    rdreg(4'h3, v); check("R9 overrun ignored", v, 16'h007E);
    check("R9 overrun error", n_err - e0, 1);
    e0 = n_err;
    write_bytes(8'hE5, 8'h99);
    rdreg(4'h5, v); check("R4 ext needs six nibbles", v, 16'h1234);
    check("R4 ext short error", n_err - e0, 1);
  endtask

  task automatic t_gap();
    logic [15:0] v; int e0 = n_err;
    open_tx(); nib(4'h1); nib(4'h7); nib(4'h1); nib(4'h1);
    @(negedge clk) cs_n_i = 1'b1; cyc(2);
    open_tx(); nib(4'h1); nib(4'h3); nib(4'h9); nib(4'h9); close_tx();
    rdreg(4'h7, v); check("R10 first write kept", v, 16'h0011);
    rdreg(4'h3, v); check("R10 early write dropped", v, 16'h007E);
    check("R10 no error", n_err - e0, 0);
  endtask

  task automatic t_empty();
    int e0 = n_err;
    open_tx(); close_tx();
    check("R11 empty select", n_err - e0, 0);
    check("R11 oe idle", bus_oe_o, 0);
  endtask

  initial begin
    cyc(4);
    @(negedge clk) rst = 1'b0;
    cyc(20);
    t_reset();
    t_normal();
    t_ext();
    t_read();
    t_read_abort();
    t_abort_write();
    t_overrun();
    t_gap();
    t_empty();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    cyc(100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule